// File: doc/BRIEF.md
# Dual-Path Latch/Register Bus Transceiver

This block moves an 18-bit word between two buses, A and B, with a separate path for each direction. Each path has its own storage. A latch-enable input selects how that storage behaves. With latch enable high the path is transparent and the far bus follows the near bus at once. With latch enable low the storage takes a new word only on a rising edge of the path's own strobe input, and otherwise holds its value.

Tri-state pads are modelled as a value bus and an enable flag for each direction, so the block stays synthesizable. The value bus always shows the path's current word. The flag says whether the pad would drive it. The A-to-B enable is active high and the B-to-A enable is active low. The strobe inputs are data signals: each is sampled on the system clock, and its rising edge is found by comparing it with the previous sample. No clock is gated.

Top module: `dual_path_xcvr`

## Requirements
- R1: While ab_le_i is 1, b_o equals a_i in the same cycle, with no register in between.
- R2: While ab_le_i is 0, a rising strobe edge captures a_i into the A-to-B storage. A rising edge means ab_ck_i is sampled 1 at a clk_i edge after being sampled 0 at the clk_i edge before it. The captured word appears on b_o from the cycle after that clk_i edge.
- R3: While ab_le_i is 0 and ab_ck_i stays at 1 or stays at 0, b_o keeps its value and changes on a_i have no effect.
- R4: When ab_le_i falls, b_o keeps the a_i value sampled at the last clk_i edge with ab_le_i at 1, and holds it until the next rising strobe edge, even if ab_ck_i is high when the enable falls.
- R5: b_oe_o is 1 (drive) exactly when ab_oe_i is 1. The enable has no effect on storage: a word captured while b_oe_o is 0 shows on b_o.
- R6: The B-to-A path follows R1 to R4 with b_i, ba_le_i, ba_ck_i and a_o in place of a_i, ab_le_i, ab_ck_i and b_o.
- R7: a_oe_o is 1 (drive) exactly when ba_oe_ni is 0.
- R8: While rst_ni is 0, both storages clear to zero and both strobes count as last sampled high. A strobe held high through reset release therefore captures nothing.
- R9: The two paths are independent: strobes, enables and latch controls of one path do not change the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 18 | Word arriving from bus A |
| b_i | input | 18 | Word arriving from bus B |
| ab_oe_i | input | 1 | A-to-B output enable, active high |
| ab_le_i | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_ck_i | input | 1 | A-to-B capture strobe |
| ba_oe_ni | input | 1 | B-to-A output enable, active low |
| ba_le_i | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_ck_i | input | 1 | B-to-A capture strobe |
| b_o | output | 18 | Value presented to bus B |
| b_oe_o | output | 1 | Bus B pad drive flag |
| a_o | output | 18 | Value presented to bus A |
| a_oe_o | output | 1 | Bus A pad drive flag |

## Verification
The properties assume that the strobe inputs are synchronous to clk_i. They also assume that the strobes change no more often than once per system cycle, so each strobe edge is seen as one low sample followed by one high sample. The properties do not check the first cycle after reset release; the sampled history there starts in reset. The stimulus changes every input just after a clk_i rising edge, which keeps it inside these assumptions. It keeps each strobe low for at least one cycle before raising it, except in the reset test, which raises the strobe on purpose before release.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  parameter int unsigned DPX_W = 18;
  localparam int unsigned NUM_DIR = 2;
  typedef enum logic [0:0] {DIR_AB = 1'b0, DIR_BA = 1'b1} dir_e;
endpackage

// File: rtl/dpx_edge.sv
module dpx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic strobe_q;

  // reset as "high" so a strobe held high across release is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b1;
    else         strobe_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~strobe_q;
endmodule

// File: rtl/dpx_store.sv
module dpx_store #(
  parameter int unsigned W = dpx_pkg::DPX_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         transp_i,
  input  logic         cap_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         load;

  // track while transparent so a falling enable keeps the last seen word
  assign load = transp_i | cap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (load) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dpx_path.sv
module dpx_path #(
  parameter int unsigned W         = dpx_pkg::DPX_W,
  parameter bit          OE_ACT_LO = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic         le_i,
  input  logic         strobe_i,
  input  logic         oe_i,
  output logic [W-1:0] q_o,
  output logic         drive_o
);
  logic         rise;
  logic [W-1:0] held;

  dpx_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .rise_o  (rise)
  );

  dpx_store #(.W(W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (d_i),
    .transp_i(le_i),
    .cap_i   (rise),
    .q_o     (held)
  );

  assign q_o = le_i ? d_i : held;

  generate
    if (OE_ACT_LO) begin : g_oe_lo
      assign drive_o = ~oe_i;
    end else begin : g_oe_hi
      assign drive_o = oe_i;
    end
  endgenerate
endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int unsigned WIDTH = dpx_pkg::DPX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ab_oe_i,
  input  logic             ab_le_i,
  input  logic             ab_ck_i,
  input  logic             ba_oe_ni,
  input  logic             ba_le_i,
  input  logic             ba_ck_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o
);
  import dpx_pkg::*;

  logic [WIDTH-1:0] din  [NUM_DIR];
  logic [WIDTH-1:0] dout [NUM_DIR];
  logic             le   [NUM_DIR];
  logic             stb  [NUM_DIR];
  logic             oe   [NUM_DIR];
  logic             drv  [NUM_DIR];

  assign din[DIR_AB] = a_i;
  assign le [DIR_AB] = ab_le_i;
  assign stb[DIR_AB] = ab_ck_i;
  assign oe [DIR_AB] = ab_oe_i;
  assign din[DIR_BA] = b_i;
  assign le [DIR_BA] = ba_le_i;
  assign stb[DIR_BA] = ba_ck_i;
  assign oe [DIR_BA] = ba_oe_ni;

  generate
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
      dpx_path #(
        .W        (WIDTH),
        .OE_ACT_LO(g == int'(DIR_BA))
      ) u_path (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .d_i     (din[g]),
        .le_i    (le[g]),
        .strobe_i(stb[g]),
        .oe_i    (oe[g]),
        .q_o     (dout[g]),
        .drive_o (drv[g])
      );
    end
  endgenerate

  assign b_o    = dout[DIR_AB];
  assign b_oe_o = drv[DIR_AB];
  assign a_o    = dout[DIR_BA];
  assign a_oe_o = drv[DIR_BA];
endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
  parameter int unsigned WIDTH = dpx_pkg::DPX_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             ab_oe_i,
  input logic             ab_le_i,
  input logic             ab_ck_i,
  input logic             ba_oe_ni,
  input logic             ba_le_i,
  input logic             ba_ck_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_AB_TRANSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ab_le_i |-> b_o == a_i); // R1
  AST_AB_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ab_le_i && $rose(ab_ck_i)) |=> (ab_le_i || b_o == $past(a_i))); // R2
  AST_AB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ab_le_i && !$rose(ab_ck_i)) |=> (ab_le_i || $stable(b_o))); // R3
  AST_AB_LE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ab_le_i) |=> (ab_le_i || b_o == $past(a_i))); // R4
  AST_AB_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_oe_o == ab_oe_i); // R5
  AST_BA_TRANSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ba_le_i |-> a_o == b_i); // R6
  AST_BA_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ba_le_i && $rose(ba_ck_i)) |=> (ba_le_i || a_o == $past(b_i))); // R6
  AST_BA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !ba_le_i && !$rose(ba_ck_i)) |=> (ba_le_i || $stable(a_o))); // R6
  AST_BA_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_oe_o != ba_oe_ni); // R7
endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_path_xcvr_bench.sv
module dual_path_xcvr_bench;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         ab_oe = 1'b0, ab_le = 1'b0, ab_ck = 1'b0;
  logic         ba_oe_n = 1'b1, ba_le = 1'b0, ba_ck = 1'b0;
  logic [W-1:0] b_out, a_out;
  logic         b_oe, a_oe;

  int n_chk = 0, n_bad = 0;

  // reference state per requirements
  logic [W-1:0] st_ab = '0, st_ba = '0;
  logic         pv_ab = 1'b1, pv_ba = 1'b1;

  always #5 clk = ~clk;

  dual_path_xcvr u_dual_path_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_in), .b_i(b_in),
    .ab_oe_i(ab_oe), .ab_le_i(ab_le), .ab_ck_i(ab_ck),
    .ba_oe_ni(ba_oe_n), .ba_le_i(ba_le), .ba_ck_i(ba_ck),
    .b_o(b_out), .b_oe_o(b_oe), .a_o(a_out), .a_oe_o(a_oe)
  );

  function automatic logic [W-1:0] exp_b();
    return ab_le ? a_in : st_ab;
  endfunction
  function automatic logic [W-1:0] exp_a();
    return ba_le ? b_in : st_ba;
  endfunction

  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      st_ab = '0; st_ba = '0; pv_ab = 1'b1; pv_ba = 1'b1;
    end else begin
      if (ab_le || (ab_ck && !pv_ab)) st_ab = a_in;
      if (ba_le || (ba_ck && !pv_ba)) st_ba = b_in;
      pv_ab = ab_ck; pv_ba = ba_ck;
    end
    #2;
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(string req);
    #1;
    chk(req, b_out, exp_b());
    chk(req, a_out, exp_a());
  endtask

  task automatic t_reset();
    ab_ck = 1'b1; ba_ck = 1'b1;
    a_in = 18'h2AAAA; b_in = 18'h15555;
    tick(); tick();
    chk("R8", b_out, '0); chk("R8", a_out, '0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R8", b_out, '0); chk("R8", a_out, '0);
    chk_both("R8");
    ab_ck = 1'b0; ba_ck = 1'b0; tick();
  endtask

  task automatic t_transp_ab();
    ab_le = 1'b1;
    for (int i = 0; i < 4; i++) begin
      a_in = 18'(i * 18'h0F0F3 + 7);
      #1; chk("R1", b_out, a_in);
      tick(); chk_both("R1");
    end
  endtask

  task automatic t_le_fall_ab();
    a_in = 18'h1234A; ab_ck = 1'b1; tick();
    ab_le = 1'b0; a_in = 18'h3FFFF; tick();
    chk("R4", b_out, 18'h1234A);
    a_in = 18'h00001; tick();
    chk("R4", b_out, 18'h1234A);
    ab_ck = 1'b0; tick(); chk_both("R4");
    ab_ck = 1'b1; tick(); chk("R4", b_out, 18'h00001);
    ab_ck = 1'b0; tick();
  endtask

  task automatic t_capture_hold_ab();
    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] v = 18'(18'h0ACE1 ^ (i * 18'h11111));
      a_in = v; ab_ck = 1'b1; tick();
      chk("R2", b_out, v);
      a_in = ~v; tick(); chk("R3", b_out, v);
      ab_ck = 1'b0; tick(); chk("R3", b_out, v);
      a_in = 18'h0; tick(); chk("R3", b_out, v);
    end
  endtask

  task automatic t_oe();
    ab_oe = 1'b1; ba_oe_n = 1'b0; #1;
    n_chk++; if (b_oe !== 1'b1) begin n_bad++; $display("FAIL R5 act=%b exp=1", b_oe); end
    n_chk++; if (a_oe !== 1'b1) begin n_bad++; $display("FAIL R7 act=%b exp=1", a_oe); end
    ab_oe = 1'b0; ba_oe_n = 1'b1; #1;
    n_chk++; if (b_oe !== 1'b0) begin n_bad++; $display("FAIL R5 act=%b exp=0", b_oe); end
    n_chk++; if (a_oe !== 1'b0) begin n_bad++; $display("FAIL R7 act=%b exp=0", a_oe); end
    tick();
    // capture while disabled
    a_in = 18'h2BEEF; ab_ck = 1'b1; tick();
    chk("R5", b_out, 18'h2BEEF);
    ab_ck = 1'b0; ab_oe = 1'b1; tick(); chk("R5", b_out, 18'h2BEEF);
  endtask

  task automatic t_ba_path();
    ba_le = 1'b1; b_in = 18'h13579; #1; chk("R6", a_out, 18'h13579);
    tick(); b_in = 18'h02468; tick();
    ba_le = 1'b0; b_in = 18'h3C3C3; tick(); chk("R6", a_out, 18'h02468);
    ba_ck = 1'b1; tick(); chk("R6", a_out, 18'h3C3C3);
    b_in = 18'h0; tick(); chk("R6", a_out, 18'h3C3C3);
    ba_ck = 1'b0; tick(); chk_both("R6");
    ba_oe_n = 1'b0; b_in = 18'h1F1F1; ba_ck = 1'b1; tick(); chk("R6", a_out, 18'h1F1F1);
    ba_ck = 1'b0; tick();
  endtask

  task automatic t_independent();
    logic [W-1:0] hb = b_out;
    logic [W-1:0] ha = a_out;
    ab_le = 1'b0; ba_le = 1'b0;
    b_in = 18'h2D2D2; ba_ck = 1'b1; tick(); chk("R9", b_out, hb);
    ba_ck = 1'b0; ba_le = 1'b1; tick(); chk("R9", b_out, hb);
    ba_le = 1'b0; tick();
    ha = a_out;
    a_in = 18'h31337; ab_ck = 1'b1; ab_le = 1'b1; tick(); chk("R9", a_out, ha);
    ab_le = 1'b0; ab_ck = 1'b0; tick(); chk_both("R9");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_transp_ab();
        t_le_fall_ab();
        t_capture_hold_ab();
        t_oe();
        t_ba_path();
        t_independent();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule